// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block keeps the status register of a serial flash device and rules on each modifying command that a serial front end has already decoded. A command arrives as a one-cycle strobe with an opcode, a 24-bit address and a data byte. The block answers one cycle later with exactly one accept or reject pulse. An accepted command also updates the write-enable latch, the write-disable bit and the two block-protect bits. The block does not handle the serial shifter, the memory array or program/erase timing. A level-sensitive busy input stands in for an operation already in progress.

The active-low write-protect pin works together with the write-disable bit. While both are asserted, the status register is locked in hardware. The lock depends only on the current pin level and the current bit value, so it takes effect in whichever order the two are applied. Raising the pin is the only way out. The block-protect bits choose a protected top portion of an 18-bit effective address space. Program and erase commands aimed at that portion are refused in both the software and the hardware protection mode.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, status bits 7..1 read zero (write-disable bit clear, block-protect 00, write-enable latch clear), the mode output reads 0, and neither response pulse is high.
- R2: Opcode 1 (write enable) sets the write-enable latch in status bit 1, and opcode 2 (write disable) clears it. Both are accepted when the busy input is low.
- R3: While status bit 7 (write-disable) is 0, opcode 3 (write status) is accepted if the latch is set, at either pin level. On acceptance it loads data bit 7 into status bit 7 and data bits 3..2 into status bits 3..2.
- R4: While status bit 7 is 1 and the pin is high, write status is accepted only if the latch is set.
- R5: While status bit 7 is 1 and the pin is low, write status is rejected even with the latch set, and status bits 7 and 3..2 keep their values.
- R6: The mode output is 2 (hardware) whenever status bit 7 is 1 and the pin is low. Otherwise it is 1 (software) when status bits 3..2 are nonzero, and 0 otherwise. It follows the pin in the same cycle, whichever of the bit and the pin changed last.
- R7: Opcodes 4 (page program) and 5 (sector erase) are rejected when the address falls in the protected area, and address bits 23..18 have no effect. With A = address bits 17..0, the protected area is: none for block-protect 00, A >= 0x30000 for 01, A >= 0x20000 for 10, and all addresses for 11.
- R8: Opcode 6 (bulk erase) is rejected whenever status bits 3..2 are nonzero.
- R9: Opcodes 3 to 6 are rejected when the latch is clear. Whether accepted or rejected, they leave the latch cleared.
- R10: A command that arrives while the busy input is high is rejected and leaves status bits 7..1 unchanged.
- R11: Each command strobe yields exactly one of the accept or reject pulses, one cycle long, in the next cycle. No pulse occurs without a strobe. Opcodes 0 and 7 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode (1 wren, 2 wrdi, 3 write status, 4 program, 5 sector erase, 6 bulk erase) |
| cmd_addr | input | 24 | Target address; bits 23..18 ignored |
| cmd_wdata | input | 8 | Data byte for write status |
| wp_n | input | 1 | Active-low write-protect pin |
| busy | input | 1 | Operation in progress |
| status_o | output | 8 | Status: [7] write-disable, [3:2] block-protect, [1] latch, [0] busy |
| acc_o | output | 1 | Accept pulse |
| rej_o | output | 1 | Reject pulse |
| prot_mode_o | output | 2 | 0 unprotected, 1 software, 2 hardware |

## Verification
A change of the write-protect pin can arrive in the same cycle as a write-status command, so the pin edge and the lock decision meet. The bench drives the pin to its new level together with the command strobe. In the first case the write-disable bit is already set and the pin falls with the command, which must be rejected. In the second case the pin rises with the command, which must be accepted. The other collision is a busy input raised together with a command: a bench model that sees the same pin, busy and latch values predicts the response pulse and the status bits that follow, and the design is checked against that prediction.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WEN  = 3'd1,
    OP_WDIS = 3'd2,
    OP_WSR  = 3'd3,
    OP_PROG = 3'd4,
    OP_SERS = 3'd5,
    OP_BERS = 3'd6,
    OP_RSVD = 3'd7
  } wp_op_e;

  typedef enum logic [1:0] {
    MODE_OPEN = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_HARD = 2'd2
  } wp_mode_e;

  // Protected top fraction chosen by the block-protect code, judged on the
  // two most significant effective address bits.
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic wp_mode_e mode_of(input logic srwd, input logic wp_n, input logic [1:0] bp);
    if (srwd && !wp_n) return MODE_HARD;
    if (bp != 2'b00)   return MODE_SOFT;
    return MODE_OPEN;
  endfunction

endpackage

// File: rtl/wp_region.sv
module wp_region #(
  parameter int EFF_W = 18
) (
  input  logic [1:0]       bp,
  input  logic [EFF_W-1:0] addr,
  output logic             locked
);
  import flash_wp_pkg::*;
  localparam int MSB = EFF_W - 1;

  assign locked = region_locked(bp, addr[MSB -: 2]);
endmodule

// File: rtl/wp_gate.sv
module wp_gate (
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       busy,
  input  logic       wel,
  input  logic       srwd,
  input  logic       wp_n,
  input  logic [1:0] bp,
  input  logic       locked,
  output logic       accept,
  output logic       reject,
  output logic       wsr_commit,
  output logic       wel_set,
  output logic       wel_clr
);
  import flash_wp_pkg::*;
  wp_op_e op;
  logic   hw_lock;

  assign op      = wp_op_e'(cmd_op);
  assign hw_lock = srwd && !wp_n;

  always_comb begin
    accept     = 1'b0;
    reject     = 1'b0;
    wsr_commit = 1'b0;
    wel_set    = 1'b0;
    wel_clr    = 1'b0;
    if (cmd_valid) begin
      if (busy) begin
        reject = 1'b1;
      end else begin
        case (op)
          OP_WEN: begin
            accept  = 1'b1;
            wel_set = 1'b1;
          end
          OP_WDIS: begin
            accept  = 1'b1;
            wel_clr = 1'b1;
          end
          OP_WSR: begin
            wel_clr = 1'b1;
            if (wel && !hw_lock) begin
              accept     = 1'b1;
              wsr_commit = 1'b1;
            end else begin
              reject = 1'b1;
            end
          end
          OP_PROG, OP_SERS: begin
            wel_clr = 1'b1;
            accept  = wel && !locked;
            reject  = !(wel && !locked);
          end
          OP_BERS: begin
            wel_clr = 1'b1;
            accept  = wel && (bp == 2'b00);
            reject  = !(wel && (bp == 2'b00));
          end
          default: reject = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wsr_commit,
  input  logic [7:0] wdata,
  input  logic       wel_set,
  input  logic       wel_clr,
  output logic       srwd,
  output logic [1:0] bp,
  output logic       wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd <= 1'b0;
      bp   <= 2'b00;
      wel  <= 1'b0;
    end else begin
      if (wsr_commit) begin
        srwd <= wdata[7];
        bp   <= wdata[3:2];
      end
      if (wel_set)      wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W = 24,
  parameter int EFF_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              busy,
  output logic [7:0]        status_o,
  output logic              acc_o,
  output logic              rej_o,
  output logic [1:0]        prot_mode_o
);
  import flash_wp_pkg::*;

  logic       srwd, wel, locked;
  logic [1:0] bp;
  logic       accept, reject, wsr_commit, wel_set, wel_clr;

  wp_region #(.EFF_W(EFF_W)) u_region (
    .bp     (bp),
    .addr   (cmd_addr[EFF_W-1:0]),
    .locked (locked)
  );

  wp_gate u_gate (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .busy       (busy),
    .wel        (wel),
    .srwd       (srwd),
    .wp_n       (wp_n),
    .bp         (bp),
    .locked     (locked),
    .accept     (accept),
    .reject     (reject),
    .wsr_commit (wsr_commit),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr)
  );

  wp_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .wsr_commit (wsr_commit),
    .wdata      (cmd_wdata),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .srwd       (srwd),
    .bp         (bp),
    .wel        (wel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      acc_o <= accept;
      rej_o <= reject;
    end
  end

  assign status_o    = {srwd, 3'b000, bp, wel, busy};
  assign prot_mode_o = mode_of(srwd, wp_n, bp);
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wp_n,
  input logic       busy,
  input logic [7:0] status_o,
  input logic       acc_o,
  input logic       rej_o,
  input logic [1:0] prot_mode_o,
  input logic       wsr_commit
);
  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !(acc_o && rej_o));
  // R11
  resp_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> (acc_o || rej_o));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> (!acc_o && !rej_o));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> (rej_o && $stable(status_o[7:1])));
  // R5
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd3 && status_o[7] && !wp_n) |=> (rej_o && $stable(status_o[7:2])));
  // R9
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op >= 3'd3 && cmd_op <= 3'd6) |=> !status_o[1]);
  // R8
  bulk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd6 && status_o[3:2] != 2'b00) |=> rej_o);
  // R3
  commit_acc_chk: assert property (@(posedge clk) disable iff (!rst_n) wsr_commit |=> acc_o);
  // R6
  hard_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode_o == 2'd2) == (status_o[7] && !wp_n));
endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .wp_n        (wp_n),
  .busy        (busy),
  .status_o    (status_o),
  .acc_o       (acc_o),
  .rej_o       (rej_o),
  .prot_mode_o (prot_mode_o),
  .wsr_commit  (wsr_commit)
);

// File: tb/tb_flash_wp_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [23:0] cmd_addr = 24'd0;
  logic [7:0]  cmd_wdata = 8'd0;
  logic        wp_n = 1'b1;
  logic        busy = 1'b0;
  logic [7:0]  status_o;
  logic        acc_o, rej_o;
  logic [1:0]  prot_mode_o;

  int total = 0;
  int bad = 0;
  logic       m_srwd = 1'b0;
  logic [1:0] m_bp = 2'b00;
  logic       m_wel = 1'b0;

  always #5 clk = ~clk;

  flash_wp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n), .busy(busy),
    .status_o(status_o), .acc_o(acc_o), .rej_o(rej_o), .prot_mode_o(prot_mode_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(input logic w);
    if (m_srwd && !w) return 2;
    if (m_bp != 2'b00) return 1;
    return 0;
  endfunction

  function automatic logic in_locked(input logic [23:0] a);
    int lo;
    int ea;
    ea = int'(a[17:0]);
    case (m_bp)
      2'd0: lo = 32'h40000;
      2'd1: lo = 32'h30000;
      2'd2: lo = 32'h20000;
      default: lo = 0;
    endcase
    return ea >= lo;
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [23:0] a, input logic [7:0] d,
                     input logic wpv, input logic bz, input string tag);
    logic e_acc;
    logic [7:0] exp_st;
    e_acc = 1'b0;
    if (!bz) begin
      case (op)
        3'd1: begin e_acc = 1'b1; m_wel = 1'b1; end
        3'd2: begin e_acc = 1'b1; m_wel = 1'b0; end
        3'd3: begin
          e_acc = m_wel && !(m_srwd && !wpv);
          if (e_acc) begin m_srwd = d[7]; m_bp = d[3:2]; end
          m_wel = 1'b0;
        end
        3'd4, 3'd5: begin e_acc = m_wel && !in_locked(a); m_wel = 1'b0; end
        3'd6: begin e_acc = m_wel && (m_bp == 2'b00); m_wel = 1'b0; end
        default: e_acc = 1'b0;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; wp_n = wpv; busy = bz;
    @(negedge clk);
    cmd_valid = 1'b0; busy = 1'b0;
    check(acc_o == e_acc && rej_o == !e_acc, tag, {acc_o, rej_o}, {e_acc, !e_acc});
    exp_st = {m_srwd, 3'b000, m_bp, m_wel, 1'b0};
    check(status_o[7:1] == exp_st[7:1], tag, status_o, exp_st);
    check(int'(prot_mode_o) == exp_mode(wpv), tag, prot_mode_o, exp_mode(wpv));
  endtask

  task automatic setup(input logic s, input logic [1:0] b);
    cmd(3'd1, 24'd0, 8'd0, 1'b1, 1'b0, "R2 setup");
    cmd(3'd3, 24'd0, {s, 3'b000, b, 2'b00}, 1'b1, 1'b0, "R4 setup");
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status_o == 8'h00, "R1 status", status_o, 0);
    check(prot_mode_o == 2'd0 && !acc_o && !rej_o, "R1 mode/pulses", {prot_mode_o, acc_o, rej_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 no pulse without strobe
    check(!acc_o && !rej_o, "R11 idle", {acc_o, rej_o}, 0);

    // R2 latch set and clear
    cmd(3'd1, 24'd0, 8'd0, 1'b1, 1'b0, "R2 wren");
    cmd(3'd2, 24'd0, 8'd0, 1'b1, 1'b0, "R2 wrdi");

    // R3 write-disable clear: pin level irrelevant, latch required (R9)
    for (int w = 0; w < 2; w++) begin
      cmd(3'd3, 24'd0, 8'h0C, w[0], 1'b0, "R9 wsr no latch");
      for (int b = 0; b < 4; b++) begin
        cmd(3'd1, 24'd0, 8'd0, w[0], 1'b0, "R2 wren");
        cmd(3'd3, 24'd0, 8'h73 | 8'(b << 2), w[0], 1'b0, "R3 wsr open");
      end
      cmd(3'd1, 24'd0, 8'd0, w[0], 1'b0, "R2 wren");
      cmd(3'd3, 24'd0, 8'h00, w[0], 1'b0, "R3 wsr clear");
    end

    // R4 / R5 sweep with write-disable set
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 4; b++) begin
          setup(1'b1, 2'(3 - b));
          if (l != 0) cmd(3'd1, 24'd0, 8'd0, w[0], 1'b0, "R2 wren");
          cmd(3'd3, 24'd0, 8'h00 | 8'(b << 2), w[0], 1'b0, w == 0 ? "R5 locked wsr" : "R4 wsr");
          wp_n = 1'b1;
        end

    // R6 both orders of entry, exit by pin
    setup(1'b0, 2'b00);
    cmd(3'd1, 24'd0, 8'd0, 1'b0, 1'b0, "R2 wren");
    cmd(3'd3, 24'd0, 8'h80, 1'b0, 1'b0, "R6 bit after pin");
    @(negedge clk) wp_n = 1'b1;
    #1 check(prot_mode_o == 2'd0, "R6 exit by pin", prot_mode_o, 0);
    @(negedge clk) wp_n = 1'b0;
    #1 check(prot_mode_o == 2'd2, "R6 pin after bit", prot_mode_o, 2);
    // same-cycle collisions: pin falls / rises with the command (R5, R4)
    wp_n = 1'b1;
    cmd(3'd1, 24'd0, 8'd0, 1'b1, 1'b0, "R2 wren");
    cmd(3'd3, 24'd0, 8'h04, 1'b0, 1'b0, "R5 pin falls with wsr");
    cmd(3'd1, 24'd0, 8'd0, 1'b0, 1'b0, "R2 wren");
    cmd(3'd3, 24'd0, 8'h04, 1'b1, 1'b0, "R4 pin rises with wsr");

    // R7 / R8 program and erase sweep
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int q = 0; q < 4; q++)
            for (int op = 4; op < 7; op++)
              for (int l = 0; l < 2; l++) begin
                logic [23:0] a;
                a = {6'(q * 11 + b * 5 + op), 2'(q), 16'(q * 4660 + l * 77)};
                wp_n = 1'b1;
                setup(s[0], 2'(b));
                if (l != 0) cmd(3'd1, 24'd0, 8'd0, w[0], 1'b0, "R2 wren");
                cmd(3'(op), a, 8'd0, w[0], 1'b0,
                    op == 6 ? "R8 bulk" : (l == 0 ? "R9 no latch" : "R7 region"));
              end

    // R10 busy: every opcode rejected, state kept
    wp_n = 1'b1;
    setup(1'b0, 2'b01);
    for (int op = 0; op < 8; op++) begin
      cmd(3'd1, 24'd0, 8'd0, 1'b1, 1'b0, "R2 wren");
      cmd(3'(op), 24'h000100, 8'h8C, 1'b1, 1'b1, "R10 busy");
    end
    // R11 reserved opcodes
    cmd(3'd0, 24'd0, 8'd0, 1'b1, 1'b0, "R11 op0");
    cmd(3'd7, 24'd0, 8'd0, 1'b1, 1'b0, "R11 op7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule